// File: doc/BRIEF.md
# Gated LFSR Signature Analyzer

This block compresses the serial stream seen on one probe line into a 16-bit signature for board-level fault finding. It samples the probe on every rising edge of the clock of the circuit under test. Sampling happens only inside a measurement window. The window opens on a selectable edge of the start line and closes on a selectable edge of the stop line. In the usual setup, start and stop are both tied to the top line of a counting bus and both select its rising edge. A window then spans one full count period, so a healthy board gives the same signature on every pass.

When a window closes, the block latches the signature. It shows the signature as four ASCII display characters drawn from a 16-symbol alphabet that is not hexadecimal. It also raises a one-cycle ready pulse and reports whether the new signature matches the previous one. A separate activity output lights for a stretched interval whenever the probe changes level. This lets a single isolated pulse or a slow pulse train be seen apart from the signature.

Top module: `gated_sig_analyzer`

## Requirements
- R1: Start, stop and probe pass through two synchronizing flip-flops. A level first applied before clock edge n is acted on at edge n+2. The probe samples that enter the signature are those applied strictly after the start-edge sample and strictly before the stop-edge sample.
- R2: Each sample shifts the register left. Bit 0 takes the probe bit XOR register bits 15, 11, 8 and 6, which gives the feedback polynomial x^16+x^12+x^9+x^7+1. The register is cleared when a window opens.
- R3: A probe held low for a whole window gives signature 0x0000, shown as "0000".
- R4: start_rise_i=1 selects the rising edge of start_i as the opening event and 0 selects the falling edge. stop_rise_i selects the closing edge of stop_i in the same way.
- R5: Start edges that arrive while a window is open have no effect on the window or on its signature.
- R6: A window that closes with at least one sample copies the register to sig_o and pulses ready_o high for exactly one clock.
- R7: At each ready pulse, stable_o is set to 1 if the new signature equals the previously latched one, and to 0 otherwise. Before the first latch, stable_o is 0. stable_o holds its value between pulses.
- R8: A window that closes with no samples pulses err_o for one clock. It raises no ready pulse and leaves sig_o and stable_o unchanged.
- R9: disp_o carries one ASCII character per nibble, most significant nibble in disp_o[31:24]. Nibble values 0..15 map to 0 1 2 3 4 5 6 7 8 9 A C F H P U.
- R10: activity_o goes high one cycle after a synchronized probe change is seen. It stays high for STRETCH_CYC cycles after the last change, independently of any window.
- R11: Repeated windows over a repetitive stimulus give equal signatures. A probe held high and a toggling probe give different signatures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock of the circuit under test |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Window opening line |
| stop_i | input | 1 | Window closing line |
| probe_i | input | 1 | Probed data line |
| start_rise_i | input | 1 | 1: open on rising edge, 0: on falling edge |
| stop_rise_i | input | 1 | 1: close on rising edge, 0: on falling edge |
| sig_o | output | 16 | Latched signature |
| disp_o | output | 32 | Four ASCII display characters |
| ready_o | output | 1 | One-cycle pulse when a signature is latched |
| stable_o | output | 1 | Latched signature equals the previous one |
| err_o | output | 1 | One-cycle pulse on an empty window |
| activity_o | output | 1 | Stretched probe-change indicator |

## Verification
The bench targets the two-cycle synchronizer offset and the exclusive window ends. If either is wrong, one sample too many or too few enters the signature, and every latched value shifts. With start and stop tied to one counter line, the stop edge must not also reopen a window; a design that reopened would latch every period rather than every other. The bench places start pulses inside open windows and a stop one cycle after a start: a design that restarts on a repeated start, or latches an empty window, corrupts sig_o or misses err_o. An isolated probe pulse and a slow train check that the activity stretch neither drops short pulses nor runs a cycle long.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic {WIN_IDLE, WIN_OPEN} win_e;

  function automatic logic [7:0] glyph(input logic [3:0] n);
    case (n)
      4'd10:   glyph = 8'h41; // A
      4'd11:   glyph = 8'h43; // C
      4'd12:   glyph = 8'h46; // F
      4'd13:   glyph = 8'h48; // H
      4'd14:   glyph = 8'h50; // P
      4'd15:   glyph = 8'h55; // U
      default: glyph = 8'h30 + {4'd0, n};
    endcase
  endfunction
endpackage

// File: rtl/sa_sync.sv
module sa_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff1_q, ff2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= '0;
      ff2_q <= '0;
    end else begin
      ff1_q <= d_i;
      ff2_q <= ff1_q;
    end
  end
  assign q_o = ff2_q;
endmodule

// File: rtl/sa_edge.sv
module sa_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_sel_i,
  output logic evt_o
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end
  assign evt_o = rise_sel_i ? (lvl_i & ~prev_q) : (~lvl_i & prev_q);
endmodule

// File: rtl/sa_lfsr.sv
module sa_lfsr #(
  parameter int          W        = 16,
  parameter logic [W-1:0] TAP_MASK = 16'h8940
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] sr_q;
  logic         fb;
  assign fb = bit_i ^ (^(sr_q & TAP_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (clr_i) sr_q <= '0;
    else if (en_i)  sr_q <= {sr_q[W-2:0], fb};
  end
  assign state_o = sr_q;

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sr_q == '0));
  assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (sr_q[W-1:1] == $past(sr_q[W-2:0])));
endmodule

// File: rtl/sa_stretch.sv
module sa_stretch #(
  parameter int STRETCH_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic act_o
);
  localparam int CW = $clog2(STRETCH_CYC + 1);
  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          chg;
  assign chg = lvl_i ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      if (chg)              cnt_q <= CW'(STRETCH_CYC);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end
  assign act_o = (cnt_q != '0);

  assert_act_on_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> act_o);
endmodule

// File: rtl/gated_sig_analyzer.sv
module gated_sig_analyzer
  import sa_pkg::*;
#(
  parameter int          SIG_W       = 16,
  parameter logic [15:0] TAP_MASK    = 16'h8940,
  parameter int          STRETCH_CYC = 4096
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               probe_i,
  input  logic               start_rise_i,
  input  logic               stop_rise_i,
  output logic [SIG_W-1:0]   sig_o,
  output logic [2*SIG_W-1:0] disp_o,
  output logic               ready_o,
  output logic               stable_o,
  output logic               err_o,
  output logic               activity_o
);
  localparam int NIB = SIG_W / 4;

  logic [2:0]       sync_q;
  logic             start_evt, stop_evt;
  logic [SIG_W-1:0] lfsr_state;
  win_e             win_q;
  logic             seen_q, have_q;
  logic [SIG_W-1:0] sig_q;
  logic             ready_q, stable_q, err_q;
  logic             open_now, close_now, shift_en;

  sa_sync #(.W(3)) u_sync (
    .clk_i, .rst_ni, .d_i({probe_i, stop_i, start_i}), .q_o(sync_q)
  );

  sa_edge u_start_edge (
    .clk_i, .rst_ni, .lvl_i(sync_q[0]), .rise_sel_i(start_rise_i), .evt_o(start_evt)
  );
  sa_edge u_stop_edge (
    .clk_i, .rst_ni, .lvl_i(sync_q[1]), .rise_sel_i(stop_rise_i), .evt_o(stop_evt)
  );

  assign open_now  = (win_q == WIN_IDLE) && start_evt;
  assign close_now = (win_q == WIN_OPEN) && stop_evt;
  assign shift_en  = (win_q == WIN_OPEN) && !stop_evt;

  sa_lfsr #(.W(SIG_W), .TAP_MASK(TAP_MASK[SIG_W-1:0])) u_lfsr (
    .clk_i, .rst_ni, .clr_i(open_now), .en_i(shift_en), .bit_i(sync_q[2]),
    .state_o(lfsr_state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= WIN_IDLE;
      seen_q   <= 1'b0;
      have_q   <= 1'b0;
      sig_q    <= '0;
      ready_q  <= 1'b0;
      stable_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      if (open_now) begin
        win_q  <= WIN_OPEN;
        seen_q <= 1'b0;
      end else if (close_now) begin
        win_q <= WIN_IDLE;
        if (seen_q) begin
          stable_q <= have_q && (lfsr_state == sig_q);
          sig_q    <= lfsr_state;
          have_q   <= 1'b1;
          ready_q  <= 1'b1;
        end else begin
          err_q <= 1'b1;
        end
      end else if (shift_en) begin
        seen_q <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NIB; g++) begin : g_disp
    assign disp_o[8*g +: 8] = glyph(sig_q[4*g +: 4]);
  end

  sa_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk_i, .rst_ni, .lvl_i(sync_q[2]), .act_o(activity_o)
  );

  assign sig_o    = sig_q;
  assign ready_o  = ready_q;
  assign stable_o = stable_q;
  assign err_o    = err_q;

  assert_ready_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  assert_ready_err_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && err_o));
  assert_empty_keeps_sig_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(sig_o) && $stable(stable_o)));
  assert_start_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q == WIN_OPEN && start_evt && !stop_evt) |=> (win_q == WIN_OPEN));
  assert_stable_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && stable_o) |-> (sig_o == $past(sig_o)));
endmodule

// File: tb/gated_sig_analyzer_tb_top.sv
module gated_sig_analyzer_tb_top;
  localparam int STR = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, probe_i = 1'b0;
  logic start_rise_i = 1'b1, stop_rise_i = 1'b1;
  logic [15:0] sig_o;
  logic [31:0] disp_o;
  logic ready_o, stable_o, err_o, activity_o;

  gated_sig_analyzer #(.SIG_W(16), .TAP_MASK(16'h8940), .STRETCH_CYC(STR)) dut_i (
    .clk_i(clk), .rst_ni, .start_i, .stop_i, .probe_i, .start_rise_i, .stop_rise_i,
    .sig_o, .disp_o, .ready_o, .stable_o, .err_o, .activity_o
  );

  always #4 clk = ~clk;

  int vectors = 0, miscmp = 0;
  bit finished = 0;

  typedef struct packed {
    logic rdy; logic err; logic stb; logic act; logic [15:0] sig;
  } exp_t;
  exp_t d0, d1, d2;

  bit m_open = 0, m_have = 0, m_stb = 0;
  logic [15:0] m_r = '0, m_sig = '0;
  int m_n = 0, m_act = 0;
  logic pst = 0, psp = 0, ppr = 0;
  logic [31:0] lcg = 32'h1234_5678;

  function automatic logic [15:0] lfsr_step(logic [15:0] r, logic b);
    logic fb;
    fb = b ^ r[15] ^ r[11] ^ r[8] ^ r[6];
    return {r[14:0], fb};
  endfunction

  function automatic logic [31:0] glyphs(logic [15:0] s);
    string tbl = "0123456789ACFHPU";
    logic [31:0] g;
    for (int i = 0; i < 4; i++) g[8*i +: 8] = tbl[int'(s[4*i +: 4])];
    return g;
  endfunction

  task automatic fail(string req, string what, logic [31:0] got, logic [31:0] exp);
    miscmp++;
    $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
  endtask

  task automatic check_out();
    vectors++;
    if (ready_o !== d2.rdy)    fail("R6", "ready_o", 32'(ready_o), 32'(d2.rdy));
    if (err_o !== d2.err)      fail("R8", "err_o", 32'(err_o), 32'(d2.err));
    if (stable_o !== d2.stb)   fail("R7", "stable_o", 32'(stable_o), 32'(d2.stb));
    if (activity_o !== d2.act) fail("R10", "activity_o", 32'(activity_o), 32'(d2.act));
    if (sig_o !== d2.sig)      fail("R2", "sig_o", 32'(sig_o), 32'(d2.sig));
    if (disp_o !== glyphs(d2.sig)) fail("R9", "disp_o", disp_o, glyphs(d2.sig));
  endtask

  // One input sample; model runs in the input index frame, outputs lag 3 negedges (R1)
  task automatic step(logic st, logic sp, logic pr);
    logic sev, pev;
    exp_t e;
    @(negedge clk);
    check_out();
    d2 = d1; d1 = d0;
    sev = start_rise_i ? (st & ~pst) : (~st & pst);
    pev = stop_rise_i  ? (sp & ~psp) : (~sp & psp);
    e = '0;
    if (!m_open) begin
      if (sev) begin m_open = 1; m_r = '0; m_n = 0; end  // R5: only when idle
    end else if (pev) begin
      m_open = 0;
      if (m_n == 0) e.err = 1;
      else begin
        m_stb = m_have && (m_r == m_sig);
        m_sig = m_r; m_have = 1; e.rdy = 1;
      end
    end else begin
      m_r = lfsr_step(m_r, pr); m_n++;
    end
    if (pr != ppr) m_act = STR;
    else if (m_act > 0) m_act--;
    e.stb = m_stb; e.sig = m_sig; e.act = (m_act != 0);
    d0 = e;
    pst = st; psp = sp; ppr = pr;
    start_i = st; stop_i = sp; probe_i = pr;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  // start and stop on the top line of a 6-bit counter
  task automatic run_counter(int sel, int periods);
    logic pr;
    for (int c = 0; c < 64 * periods; c++) begin
      logic [5:0] v;
      v = 6'(c);
      if (sel < 6)       pr = v[sel];
      else if (sel == 6) pr = 1'b1;
      else if (sel == 7) pr = 1'b0;
      else               pr = ^(v & 6'h2d);
      step(v[5], v[5], pr);
    end
  endtask

  logic [15:0] sig_high, sig_tog;

  initial begin
    exp_t z;
    z = '0;
    d0 = z; d1 = z; d2 = z;
    repeat (3) @(negedge clk);
    vectors++;
    if (ready_o !== 0 || err_o !== 0 || stable_o !== 0 || activity_o !== 0 || sig_o !== 0)
      fail("R6", "reset state", {ready_o, err_o, stable_o, activity_o, 12'd0, sig_o}, 32'd0);
    rst_ni = 1'b1;
    idle(4);

    // R3: probe low over full windows
    run_counter(7, 5);
    vectors++;
    if (disp_o !== 32'h3030_3030) fail("R3", "disp_o zero window", disp_o, 32'h3030_3030);

    // R1/R2/R7/R9: sweep of probe patterns, rising edges
    for (int s = 0; s < 9; s++) begin
      idle(4);
      run_counter(s, 5);
      if (s == 6) sig_high = sig_o;
      if (s == 0) sig_tog  = sig_o;
      vectors++;  // R11: repeated windows give equal signatures
      if (stable_o !== 1'b1) fail("R11", "repeat stable", 32'(stable_o), 32'd1);
    end
    vectors++;
    if (sig_high === sig_tog) fail("R11", "high vs toggle distinct", 32'(sig_high), 32'(~sig_tog));

    // R4: falling/falling and rising/falling edge selection
    for (int m = 0; m < 2; m++) begin
      idle(4);
      start_rise_i = 1'(m); stop_rise_i = 1'b0;
      for (int s = 0; s < 9; s += 4) begin
        idle(4);
        run_counter(s, 4);
      end
    end
    idle(4);
    start_rise_i = 1'b1; stop_rise_i = 1'b1;

    // R5: extra start pulses inside open windows, separate stop line
    for (int k = 0; k < 6; k++) begin
      idle(4);
      for (int t = 0; t < 40; t++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        step((t == 2) || (t == 10 + k) || (t == 20), (t >= 30 && t < 33), lcg[17]);
      end
    end

    // R8: empty window, stop right after start
    for (int gap = 1; gap <= 3; gap++) begin
      idle(6);
      for (int t = 0; t < 8; t++) step(t >= 2, t >= 2 + gap, 1'b1);
    end
    idle(6);

    // R10: isolated pulse and slow pulse train
    idle(20);
    step(0, 0, 1);
    idle(30);
    for (int p = 0; p < 6; p++) begin
      step(0, 0, 1); step(0, 0, 1);
      idle(18);
    end
    idle(12);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end
endmodule